// File: doc/BRIEF.md
# Banked Real-Time Clock Host Register Interface

This block is the host-facing register file of a real-time clock. A host bus with a 4-bit address, 4-bit write data, 4-bit read data and level read and write strobes reaches thirty-one distinct 4-bit registers arranged as two banks. Bank 0 carries the BCD time and date digits, the day of week and three control registers. Bank 1 carries the alarm digits, an alarm-range enable nibble and three further control registers. The register at address 0xF is shared by both banks, and its top bit picks which bank addresses 0x0 to 0xE reach.

Each control bit has its own access rule. There are read-only status bits, flags that clear when read, flags that a write can only clear, a register that keeps what is written but always reads as zero, and bits that do not exist and read as zero. A write-protect key bit in bank 1 must be 1 before the bank bit or the key itself can change. Clearing the key takes hold only after a settling delay, and once it is clear it stays clear until reset. The counting and alarm logic sit outside this block. Simple event inputs stand in for them so that the flags can be set.

The host access controller has three states. `HOST_IDLE` waits for a strobe. A rising read strobe fires one read and moves to `HOST_READ`, and a rising write strobe without a read fires one write and moves to `HOST_WRITE`. Each of those states returns to `HOST_IDLE` when its strobe falls. The key controller has three states: `DP_OPEN` (key 1), `DP_CLOSING` (key still reads 1 while a delay counter runs; a write of 0 to the key enters it from `DP_OPEN`) and `DP_SHUT` (key 0, entered when the counter expires, left only by reset).

Top module: `rtcif_top`

## Requirements
- R1: After reset, every register in both banks reads 0, except that the key bit (bank 1 address 0xE, bit 0) reads 1 and the bank bit (address 0xF, bit 3) is 0.
- R2: In bank 0, addresses 0x0 to 0xC hold, in this order, the seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens (bit 2 = PM when 1), day units, day tens, month units, month tens, year units, year tens and day of week. Writing 0xF to each reads back F,7,F,7,F,7,F,3,F,1,F,F,7, because absent bits read 0.
- R3: Address 0xF bit 3 selects bank 1 when 1. In bank 1, addresses 0x0 to 0xA hold the alarm digits and alarm day of week, and 0xB holds a 4-bit range enable. Writing 0xF to each reads back F,7,F,7,F,7,F,3,F,1,7,F. Bank 0 contents are untouched by bank 1 writes.
- R4: With parameter STAR_RAM = 0 (default), the optional storage bits (day tens bits 3:2, month tens bits 3:1, alarm seconds, minutes, hours tens and alarm day-of-week bit 3) cannot be written and read 0.
- R5: Read data appears in the cycle after the read strobe rises and holds until the next read. One strobe assertion performs exactly one access, however long it is held.
- R6: Address 0xF bit 0 is a read-only flag. `tick_evt` sets it, and a read of 0xF clears it after returning the pre-clear value.
- R7: Bank 0 address 0xD bit 3 and bit 2 choose the mode of flag 2 (0xE bit 1) and flag 1 (0xE bit 0). In mode 1, a read of 0xE clears the flag after returning it.
- R8: In mode 0, a read leaves the flag set, a write of 0 to its bit clears it, and a write of 1 has no effect. Bit 2 of 0xE is plain storage.
- R9: A set event in the same cycle as a clearing read leaves the flag set.
- R10: Bank 0 address 0xE bit 3 shows the `stat_lvl` input and ignores writes.
- R11: Bank 1 address 0xC accepts writes of bits 1:0, but any read clears it and always returns 0. Address 0xD has bits 2:0 only.
- R12: The bank bit changes only while the key reads 1. A write of 0 to the key leaves it reading 1 for DP_DELAY cycles, then it reads 0 and stays 0. Writes of 1 to the key then have no effect.
- R13: With HAS_HDSFT = 0 (default), bank 1 address 0xE bit 3 reads 0. Bits 2 (24/12 select) and 1 are plain storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address within the selected bank |
| bus_rd | input | 1 | Read strobe, level; its rising edge starts a read |
| bus_wr | input | 1 | Write strobe, level; its rising edge starts a write |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, registered |
| tick_evt | input | 1 | Sets the update flag |
| irq_set | input | 2 | Bit 0 sets flag 1, bit 1 sets flag 2 |
| stat_lvl | input | 1 | Live status shown read-only in bank 0 0xE bit 3 |

## Verification
The register map is first driven with all-ones writes to every address in both banks. The read-back masks separate the two banks' decoding and show which bits exist, and a later read in the other bank shows that bank 0 and bank 1 stay apart. The flags are driven with set events alone, with reads in each mode, with writes of 0 and of 1, and with a set coinciding with a clearing read. This tells clear-on-read apart from write-to-clear and shows that a set is never lost. A read strobe held for several cycles across a set event confirms that one strobe performs one access. The key sequence reads the key inside and after the settling window, then attempts bank and key writes, which separates the delayed lock from an immediate one.

// File: rtl/rtcif_pkg.sv
package rtcif_pkg;

    localparam int NIB = 4;
    localparam int TM_REGS = 13;
    localparam int AL_REGS = 12;

    localparam logic [3:0] A_WDAY = 4'hC;
    localparam logic [3:0] A_CTLD = 4'hD;
    localparam logic [3:0] A_CTLE = 4'hE;
    localparam logic [3:0] A_CTLF = 4'hF;
    localparam logic [3:0] A_AEN  = 4'hB;
    localparam logic [3:0] A_CP   = 4'hC;
    localparam logic [3:0] A_DP   = 4'hD;
    localparam logic [3:0] A_EP   = 4'hE;

    typedef enum logic [1:0] {HOST_IDLE, HOST_READ, HOST_WRITE} host_st_t;
    typedef enum logic [1:0] {DP_OPEN, DP_CLOSING, DP_SHUT} dp_st_t;

    // bits always present in a time register
    function automatic logic [3:0] tm_fixed(input int idx);
        case (idx)
            1, 3, 5, 12: return 4'h7;
            7:           return 4'h3;
            9:           return 4'h1;
            default:     return 4'hF;
        endcase
    endfunction

    // optional storage bits of a time register
    function automatic logic [3:0] tm_star(input int idx);
        case (idx)
            7:       return 4'hC;
            9:       return 4'hE;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [3:0] al_fixed(input int idx);
        case (idx)
            1, 3, 5, 10: return 4'h7;
            7:           return 4'h3;
            9:           return 4'h1;
            default:     return 4'hF;
        endcase
    endfunction

    function automatic logic [3:0] al_star(input int idx);
        case (idx)
            1, 3, 5, 10: return 4'h8;
            7:           return 4'hC;
            9:           return 4'hE;
            default:     return 4'h0;
        endcase
    endfunction

endpackage

// File: rtl/rtcif_host_fsm.sv
module rtcif_host_fsm
    import rtcif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rd,
    input  logic bus_wr,
    output logic rd_fire,
    output logic wr_fire
);

    host_st_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HOST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HOST_IDLE: begin
                if (bus_rd)      st_d = HOST_READ;
                else if (bus_wr) st_d = HOST_WRITE;
            end
            HOST_READ:  if (!bus_rd) st_d = HOST_IDLE;
            HOST_WRITE: if (!bus_wr) st_d = HOST_IDLE;
            default:    st_d = HOST_IDLE;
        endcase
    end

    always_comb begin
        rd_fire = (st_q == HOST_IDLE) && bus_rd;
        wr_fire = (st_q == HOST_IDLE) && bus_wr && !bus_rd;
    end

    // R5
    held_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && bus_rd) |=> (!rd_fire || !$past(bus_rd)) && (st_q == HOST_READ));

endmodule

// File: rtl/rtcif_dp_lock.sv
module rtcif_dp_lock
    import rtcif_pkg::*;
#(
    parameter int DP_DELAY = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic key_bit,
    output logic dp_now,
    output logic dp_gate
);

    localparam int CW = $clog2(DP_DELAY + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(DP_DELAY - 1);

    dp_st_t st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= DP_OPEN;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == DP_OPEN && st_d == DP_CLOSING) cnt_q <= CNT_LOAD;
            else if (st_q == DP_CLOSING && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DP_OPEN:    if (key_wr && !key_bit) st_d = DP_CLOSING;
            DP_CLOSING: if (cnt_q == '0) st_d = DP_SHUT;
            DP_SHUT:    st_d = DP_SHUT;
            default:    st_d = DP_SHUT;
        endcase
    end

    always_comb begin
        dp_now  = (st_q != DP_SHUT);
        dp_gate = (st_q != DP_SHUT);
    end

    // R12
    dp_stays_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DP_SHUT) |=> (st_q == DP_SHUT) && !dp_now);

    // R12
    dp_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !key_bit && st_q == DP_OPEN) |=> dp_now);

endmodule

// File: rtl/rtcif_regfile.sv
module rtcif_regfile
    import rtcif_pkg::*;
#(
    parameter bit STAR_RAM  = 1'b0,
    parameter bit HAS_HDSFT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_fire,
    input  logic       wr_fire,
    input  logic [3:0] addr,
    input  logic [3:0] wdata,
    input  logic       tick_evt,
    input  logic [1:0] irq_set,
    input  logic       stat_lvl,
    input  logic       dp_now,
    input  logic       dp_gate,
    output logic       key_wr,
    output logic [3:0] rdata
);

    logic [NIB-1:0] tm_q [TM_REGS];
    logic [NIB-1:0] al_q [AL_REGS];

    logic itpls2_q, itpls1_q, mask2_q, mask1_q;
    logic rest_q, irq2_q, irq1_q;
    logic bank_q, stop_q, adj_q, rdflag_q;
    logic [1:0] cp_q;
    logic [2:0] dpr_q;
    logic hdsft_q, h24_q, cal_q;

    logic view0, wr_b0, wr_b1, rd_e0, rd_f;
    logic [3:0] rmux;

    always_comb begin
        view0 = !bank_q || (addr == A_CTLF);
        wr_b0 = wr_fire && view0;
        wr_b1 = wr_fire && !view0;
        rd_e0 = rd_fire && view0 && (addr == A_CTLE);
        rd_f  = rd_fire && (addr == A_CTLF);
        key_wr = wr_b1 && (addr == A_EP);
    end

    // digit storage, one register per index
    for (genvar i = 0; i < TM_REGS; i++) begin : g_tm
        localparam logic [3:0] WM = tm_fixed(i) | (STAR_RAM ? tm_star(i) : 4'h0);
        always_ff @(posedge clk) begin
            if (!rst_n)                           tm_q[i] <= '0;
            else if (wr_b0 && addr == 4'(i))     tm_q[i] <= wdata & WM;
        end
    end

    for (genvar j = 0; j < AL_REGS; j++) begin : g_al
        localparam logic [3:0] WM = al_fixed(j) | (STAR_RAM ? al_star(j) : 4'h0);
        always_ff @(posedge clk) begin
            if (!rst_n)                           al_q[j] <= '0;
            else if (wr_b1 && addr == 4'(j))     al_q[j] <= wdata & WM;
        end
    end

    // bank 0 control: modes and masks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {itpls2_q, itpls1_q, mask2_q, mask1_q} <= '0;
        end else if (wr_b0 && addr == A_CTLD) begin
            {itpls2_q, itpls1_q, mask2_q, mask1_q} <= wdata;
        end
    end

    // bank 0 control: event flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rest_q <= 1'b0;
            irq1_q <= 1'b0;
            irq2_q <= 1'b0;
        end else begin
            if (wr_b0 && addr == A_CTLE) rest_q <= wdata[2];

            if (irq_set[0])                                              irq1_q <= 1'b1;
            else if (rd_e0 && itpls1_q)                                  irq1_q <= 1'b0;
            else if (wr_b0 && addr == A_CTLE && !itpls1_q && !wdata[0])  irq1_q <= 1'b0;

            if (irq_set[1])                                              irq2_q <= 1'b1;
            else if (rd_e0 && itpls2_q)                                  irq2_q <= 1'b0;
            else if (wr_b0 && addr == A_CTLE && !itpls2_q && !wdata[1])  irq2_q <= 1'b0;
        end
    end

    // shared register at the top address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q   <= 1'b0;
            stop_q   <= 1'b0;
            adj_q    <= 1'b0;
            rdflag_q <= 1'b0;
        end else begin
            if (wr_b0 && addr == A_CTLF) begin
                stop_q <= wdata[2];
                adj_q  <= wdata[1];
                if (dp_gate) bank_q <= wdata[3];
            end
            if (tick_evt)  rdflag_q <= 1'b1;
            else if (rd_f) rdflag_q <= 1'b0;
        end
    end

    // bank 1 control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_q    <= '0;
            dpr_q   <= '0;
            hdsft_q <= 1'b0;
            h24_q   <= 1'b0;
            cal_q   <= 1'b0;
        end else begin
            if (rd_fire && !view0 && addr == A_CP)    cp_q <= '0;
            else if (wr_b1 && addr == A_CP)           cp_q <= wdata[1:0];
            if (wr_b1 && addr == A_DP)                dpr_q <= wdata[2:0];
            if (key_wr) begin
                hdsft_q <= HAS_HDSFT ? wdata[3] : 1'b0;
                h24_q   <= wdata[2];
                cal_q   <= wdata[1];
            end
        end
    end

    // read selection
    always_comb begin
        rmux = '0;
        if (view0) begin
            for (int k = 0; k < TM_REGS; k++)
                if (addr == 4'(k)) rmux = tm_q[k];
            unique case (addr)
                A_CTLD:  rmux = {itpls2_q, itpls1_q, mask2_q, mask1_q};
                A_CTLE:  rmux = {stat_lvl, rest_q, irq2_q, irq1_q};
                A_CTLF:  rmux = {bank_q, stop_q, adj_q, rdflag_q};
                default: ;
            endcase
        end else begin
            for (int k = 0; k < AL_REGS; k++)
                if (addr == 4'(k)) rmux = al_q[k];
            unique case (addr)
                A_CP:    rmux = 4'h0;
                A_DP:    rmux = {1'b0, dpr_q};
                A_EP:    rmux = {hdsft_q, h24_q, cal_q, dp_now};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (rd_fire) rdata <= rmux;
    end

    // R6
    rdflag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_f && !tick_evt) |=> !rdflag_q);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt |=> rdflag_q);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_e0 && !itpls1_q && irq1_q) |=> irq1_q);

    // R11
    cprime_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !view0 && addr == A_CP) |=> (rdata == 4'h0) && (cp_q == 2'b00));

    // R12
    bank_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_gate |=> $stable(bank_q));

endmodule

// File: rtl/rtcif_top.sv
module rtcif_top
    import rtcif_pkg::*;
#(
    parameter bit STAR_RAM  = 1'b0,
    parameter bit HAS_HDSFT = 1'b0,
    parameter int DP_DELAY  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [3:0] bus_wdata,
    output logic [3:0] bus_rdata,
    input  logic       tick_evt,
    input  logic [1:0] irq_set,
    input  logic       stat_lvl
);

    logic rd_fire, wr_fire, key_wr, dp_now, dp_gate;

    rtcif_host_fsm u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .rd_fire (rd_fire),
        .wr_fire (wr_fire)
    );

    rtcif_dp_lock #(.DP_DELAY(DP_DELAY)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_bit (bus_wdata[0]),
        .dp_now  (dp_now),
        .dp_gate (dp_gate)
    );

    rtcif_regfile #(.STAR_RAM(STAR_RAM), .HAS_HDSFT(HAS_HDSFT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fire  (rd_fire),
        .wr_fire  (wr_fire),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .tick_evt (tick_evt),
        .irq_set  (irq_set),
        .stat_lvl (stat_lvl),
        .dp_now   (dp_now),
        .dp_gate  (dp_gate),
        .key_wr   (key_wr),
        .rdata    (bus_rdata)
    );

    // R5
    fire_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_fire, wr_fire}));

endmodule

// File: tb/sim_rtcif_top.sv
module sim_rtcif_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       tick_evt = 1'b0;
    logic [1:0] irq_set = '0;
    logic       stat_lvl = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtcif_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_evt(tick_evt), .irq_set(irq_set), .stat_lvl(stat_lvl)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [3:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [3:0] exp);
        logic [3:0] d;
        do_rd(a, d);
        check(req, d, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_evt = 1'b1;
        @(negedge clk); tick_evt = 1'b0;
    endtask

    task automatic pulse_irq(input logic [1:0] v);
        @(negedge clk); irq_set = v;
        @(negedge clk); irq_set = 2'b00;
    endtask

    // R1
    task automatic t_reset();
        for (int a = 0; a < 16; a++) rd_chk("R1 bank0 reset", 4'(a), 4'h0);
        do_wr(4'hF, 4'h8);
        rd_chk("R1 key bit reset", 4'hE, 4'h1);
        rd_chk("R1 bank1 digit reset", 4'h0, 4'h0);
        do_wr(4'hF, 4'h0);
    endtask

    // R2 R4
    task automatic t_map0();
        logic [3:0] exp0 [13] = '{4'hF, 4'h7, 4'hF, 4'h7, 4'hF, 4'h7, 4'hF,
                                   4'h3, 4'hF, 4'h1, 4'hF, 4'hF, 4'h7};
        for (int a = 0; a < 13; a++) do_wr(4'(a), 4'hF);
        for (int a = 0; a < 13; a++) rd_chk("R2 R4 bank0 map", 4'(a), exp0[a]);
    endtask

    // R3 R4 R11 R13
    task automatic t_map1();
        logic [3:0] exp1 [12] = '{4'hF, 4'h7, 4'hF, 4'h7, 4'hF, 4'h7, 4'hF,
                                   4'h3, 4'hF, 4'h1, 4'h7, 4'hF};
        do_wr(4'hF, 4'h8);
        for (int a = 0; a < 12; a++) do_wr(4'(a), 4'hF);
        for (int a = 0; a < 12; a++) rd_chk("R3 R4 bank1 map", 4'(a), exp1[a]);
        rd_chk("R3 shared reg in bank1", 4'hF, 4'h8);
        do_wr(4'h0, 4'h5);
        rd_chk("R3 bank1 digit", 4'h0, 4'h5);
        do_wr(4'hC, 4'h3);
        rd_chk("R11 cprime reads 0", 4'hC, 4'h0);
        do_wr(4'hD, 4'hF);
        rd_chk("R11 reg D width", 4'hD, 4'h7);
        do_wr(4'hE, 4'hF);
        rd_chk("R13 hdsft tied 0", 4'hE, 4'h7);
        do_wr(4'hE, 4'h1);
        rd_chk("R13 storage bits clear", 4'hE, 4'h1);
        do_wr(4'hF, 4'h0);
        rd_chk("R3 bank0 kept", 4'h0, 4'hF);
    endtask

    // R6 R5
    task automatic t_readflag();
        pulse_tick();
        rd_chk("R6 flag set, pre-clear value", 4'hF, 4'h1);
        rd_chk("R6 flag cleared by read", 4'hF, 4'h0);
        do_wr(4'hF, 4'h1);
        rd_chk("R6 flag read-only", 4'hF, 4'h0);
    endtask

    // R7 R8 R10
    task automatic t_irq();
        do_wr(4'hD, 4'hC);
        pulse_irq(2'b11);
        rd_chk("R7 flags set", 4'hE, 4'h3);
        rd_chk("R7 cleared on read", 4'hE, 4'h0);
        pulse_irq(2'b11);
        do_wr(4'hE, 4'h0);
        rd_chk("R7 write no effect in mode 1", 4'hE, 4'h3);
        rd_chk("R7 clear after", 4'hE, 4'h0);
        do_wr(4'hD, 4'h0);
        pulse_irq(2'b11);
        rd_chk("R8 flags set", 4'hE, 4'h3);
        rd_chk("R8 read does not clear", 4'hE, 4'h3);
        do_wr(4'hE, 4'h3);
        rd_chk("R8 write 1 no effect", 4'hE, 4'h3);
        do_wr(4'hE, 4'h2);
        rd_chk("R8 write 0 clears flag1 only", 4'hE, 4'h2);
        do_wr(4'hE, 4'h4);
        rd_chk("R8 rest bit stored", 4'hE, 4'h4);
        do_wr(4'hE, 4'h0);
        rd_chk("R8 all clear", 4'hE, 4'h0);
        @(negedge clk); stat_lvl = 1'b1;
        rd_chk("R10 status level", 4'hE, 4'h8);
        do_wr(4'hE, 4'h0);
        rd_chk("R10 status ignores write", 4'hE, 4'h8);
        @(negedge clk); stat_lvl = 1'b0;
        rd_chk("R10 status low", 4'hE, 4'h0);
    endtask

    // R9
    task automatic t_collide();
        pulse_tick();
        @(negedge clk); bus_addr = 4'hF; bus_rd = 1'b1; tick_evt = 1'b1;
        @(negedge clk); bus_rd = 1'b0; tick_evt = 1'b0;
        check("R9 read value with set", bus_rdata, 4'h1);
        @(negedge clk);
        rd_chk("R9 set beat clear", 4'hF, 4'h1);
        rd_chk("R9 then clears", 4'hF, 4'h0);
        do_wr(4'hD, 4'h4);
        pulse_irq(2'b01);
        @(negedge clk); bus_addr = 4'hE; bus_rd = 1'b1; irq_set = 2'b01;
        @(negedge clk); bus_rd = 1'b0; irq_set = 2'b00;
        @(negedge clk);
        rd_chk("R9 irq set beat clear", 4'hE, 4'h1);
        rd_chk("R9 irq then clears", 4'hE, 4'h0);
    endtask

    // R5
    task automatic t_hold();
        pulse_tick();
        @(negedge clk); bus_addr = 4'hF; bus_rd = 1'b1;
        @(negedge clk);
        check("R5 data after edge", bus_rdata, 4'h1);
        tick_evt = 1'b1;
        @(negedge clk); tick_evt = 1'b0;
        @(negedge clk);
        check("R5 data held", bus_rdata, 4'h1);
        bus_rd = 1'b0;
        @(negedge clk);
        rd_chk("R5 one access per strobe", 4'hF, 4'h1);
        rd_chk("R5 later read clears", 4'hF, 4'h0);
    endtask

    // R12
    task automatic t_dp();
        do_wr(4'hF, 4'h8);
        do_wr(4'hE, 4'h0);
        rd_chk("R12 key still 1 in delay", 4'hE, 4'h1);
        repeat (8) @(negedge clk);
        rd_chk("R12 key 0 after delay", 4'hE, 4'h0);
        do_wr(4'hF, 4'h0);
        rd_chk("R12 bank locked", 4'hF, 4'h8);
        rd_chk("R12 still bank1 view", 4'h0, 4'h5);
        do_wr(4'hE, 4'h1);
        rd_chk("R12 key cannot reopen", 4'hE, 4'h0);
        do_wr(4'hF, 4'h4);
        rd_chk("R12 other bits still writable", 4'hF, 4'hC);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map0();
        t_map1();
        t_readflag();
        t_irq();
        t_collide();
        t_hold();
        t_dp();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule